// File: doc/BRIEF.md
# Receive-Only Request Word Packer

This block handles the receive side of a serial port when no transmit data is involved. Software writes a byte count into a request input. The block then holds its shift-clock enable high until that many bytes have arrived from the serial shifter. The bit-level timing of the shifter is outside this block. Each arriving byte appears here as a single-cycle strobe carrying eight data bits.

In this mode the port's normal word-width setting plays no part, and the block has no input for it. Received bytes are always packed four at a time into 32-bit words. Each word is written into a small receive FIFO that the reader drains. Each FIFO entry also stores how many of its bytes are valid. A transfer can end partway through a word, and the reader learns the valid-byte count from that stored value. A live count of bytes still to be received is always visible on an output.

The shift clock pauses while the FIFO is full, so a request never overruns the storage. A new request written during an active one replaces the remaining count.

Top module: `rx_req_packer`

## Requirements
- R1: After reset the remaining-byte count is zero, `shift_run` is low, the FIFO is empty, and `fifo_vbytes` is 0.
- R2: A cycle with `req_wr` high loads `req_bytes` into `todo_bytes` at the next clock edge. From then on, `shift_run` is high while `todo_bytes` is nonzero and the FIFO is not full.
- R3: A byte is accepted when `rx_byte_stb` and `shift_run` are both high. Each accepted byte lowers `todo_bytes` by one. `shift_run` is low whenever `todo_bytes` is zero.
- R4: Accepted bytes are packed four per 32-bit word. The earliest byte of a full word goes to bits 31:24 and the latest to bits 7:0. The word is pushed into the FIFO in the cycle after its fourth byte is accepted.
- R5: When `todo_bytes` reaches zero with one to three bytes held, those bytes are pushed as a partial word. They are right-aligned, with the earliest byte in the most significant valid byte, and the unused upper bytes are zero. `fifo_vbytes` shows the head entry's valid-byte count: 1 to 3 for a partial word, 4 for a full word, and 0 when the FIFO is empty.
- R6: `shift_run` is low while the FIFO holds DEPTH words, so no entry is ever lost. Byte acceptance resumes once the reader pops a word.
- R7: A request written while a previous one is still active replaces the remaining count. Bytes already held keep packing with the bytes of the new request.
- R8: `depth_cap` reports the FIFO depth DEPTH as a 6-bit value. Software uses it to limit each request to 4*DEPTH bytes.
- R9: `rx_byte_stb` has no effect on `todo_bytes` or on the FIFO contents while `shift_run` is low.
- R10: A request of zero bytes written while one to three bytes are held pushes those bytes as a partial word, as described in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_wr | input | 1 | Request write strobe |
| req_bytes | input | CNT_W | Bytes to receive for this request |
| rx_byte_stb | input | 1 | A byte arrived from the shifter |
| rx_byte | input | 8 | Received byte value |
| shift_run | output | 1 | Shift clock enable to the shifter |
| todo_bytes | output | CNT_W | Bytes still to be received |
| fifo_rd | input | 1 | Pop the head FIFO entry |
| fifo_word | output | 32 | Head FIFO word (zero when empty) |
| fifo_vbytes | output | 3 | Valid bytes in the head word |
| fifo_level | output | LVL_W | Entries held in the FIFO |
| fifo_empty | output | 1 | FIFO holds no entry |
| depth_cap | output | 6 | FIFO depth, read-only |

## Verification
The bench builds the block with DEPTH set to 4 and the 16-bit count width. With that depth, a request of 18 bytes fills the FIFO after 16 bytes while the reader is held off. That run shows the clock pausing, the strobe being ignored while paused, and the transfer resuming once the reader drains the FIFO. The small depth also makes it quick to reach partial words of one, two and three bytes. The same is true of a mid-word request replacement and a zero-byte request that flushes held bytes.

// File: rtl/rx_req_packer_pkg.sv
// Shared types for the receive-only request packer.
package rx_req_packer_pkg;

    // One FIFO entry: packed word plus the count of valid bytes it holds.
    typedef struct packed {
        logic [31:0] word;
        logic [2:0]  nbytes;
    } rxp_entry_t;

endpackage

// File: rtl/rxp_fifo.sv
// Show-ahead FIFO of packed receive words.
// Assumes: the writer never pushes while full, and the reader pops only when not empty.
module rxp_fifo
    import rx_req_packer_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  rxp_entry_t       push_entry,
    input  logic             pop,
    output rxp_entry_t       head,
    output logic             empty,
    output logic             full,
    output logic [LVL_W-1:0] level
);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    rxp_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign empty   = (level == '0);
    assign full    = (level == FULL_LVL);
    assign head    = mem[rd_ptr];

    // Storage write; contents need no reset since level gates visibility.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_entry;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/rxp_packer.sv
// Byte counter and 32-bit word packer for receive-only requests.
// Holds up to three bytes right-aligned. It pushes on the fourth byte, or with
// fewer bytes when the remaining count reaches zero.
// Assumes: byte strobes arrive only while run is high (others are ignored).
module rxp_packer
    import rx_req_packer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_wr,
    input  logic [CNT_W-1:0] req_bytes,
    input  logic             byte_stb,
    input  logic [7:0]       byte_in,
    input  logic             fifo_full,
    output logic             run,
    output logic [CNT_W-1:0] todo,
    output logic             push,
    output rxp_entry_t       push_entry
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [23:0] acc_q;
    logic [1:0]  cnt_q;
    logic [2:0]  new_cnt;
    logic        take, last_byte, flush;

    assign run       = (todo != '0) && !fifo_full;
    assign take      = byte_stb && run;
    assign new_cnt   = {1'b0, cnt_q} + 3'd1;
    assign last_byte = (todo == ONE) && !req_wr;
    assign flush     = !take && (todo == '0) && (cnt_q != 2'd0) && !fifo_full;

    // Decide whether a word leaves this cycle and what it carries.
    always_comb begin
        push       = 1'b0;
        push_entry = '0;
        if (take && (new_cnt == 3'd4 || last_byte)) begin
            push              = 1'b1;
            push_entry.word   = {acc_q, byte_in};
            push_entry.nbytes = new_cnt;
        end else if (flush) begin
            push              = 1'b1;
            push_entry.word   = {8'h00, acc_q};
            push_entry.nbytes = {1'b0, cnt_q};
        end
    end

    // Remaining-byte counter: a request write overrides, otherwise count down.
    always_ff @(posedge clk) begin
        if (!rst_n)      todo <= '0;
        else if (req_wr) todo <= req_bytes;
        else if (take)   todo <= todo - 1'b1;
    end

    // Accumulator of held bytes, cleared whenever its contents are pushed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (push) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (take) begin
            acc_q <= {acc_q[15:0], byte_in};
            cnt_q <= new_cnt[1:0];
        end
    end
endmodule

// File: rtl/rx_req_packer.sv
// Receive-only request word packer: the counter and packer feed a show-ahead FIFO.
// Assumes: DEPTH fits in the 6-bit depth field.
module rx_req_packer
    import rx_req_packer_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_wr,
    input  logic [CNT_W-1:0] req_bytes,
    input  logic             rx_byte_stb,
    input  logic [7:0]       rx_byte,
    output logic             shift_run,
    output logic [CNT_W-1:0] todo_bytes,
    input  logic             fifo_rd,
    output logic [31:0]      fifo_word,
    output logic [2:0]       fifo_vbytes,
    output logic [LVL_W-1:0] fifo_level,
    output logic             fifo_empty,
    output logic [5:0]       depth_cap
);
    rxp_entry_t push_entry, head;
    logic       push, full;

    rxp_packer #(.CNT_W(CNT_W)) u_packer (
        .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_bytes(req_bytes),
        .byte_stb(rx_byte_stb), .byte_in(rx_byte), .fifo_full(full),
        .run(shift_run), .todo(todo_bytes), .push(push), .push_entry(push_entry)
    );

    rxp_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_entry(push_entry),
        .pop(fifo_rd), .head(head), .empty(fifo_empty), .full(full),
        .level(fifo_level)
    );

    // Present the head entry; zero when nothing is held.
    assign fifo_word   = fifo_empty ? 32'h0 : head.word;
    assign fifo_vbytes = fifo_empty ? 3'd0 : head.nbytes;
    assign depth_cap   = 6'(DEPTH);
endmodule

// File: rtl/rx_req_packer_checker.sv
// Temporal checks on the packer's ports, bound into every instance.
module rx_req_packer_checker #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_wr,
    input logic [CNT_W-1:0] req_bytes,
    input logic             rx_byte_stb,
    input logic             shift_run,
    input logic [CNT_W-1:0] todo_bytes,
    input logic [2:0]       fifo_vbytes,
    input logic [LVL_W-1:0] fifo_level,
    input logic             fifo_empty
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level == FULL_LVL) |-> !shift_run); // R6
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= FULL_LVL); // R6
    AST_IDLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (todo_bytes == '0) |-> !shift_run); // R3
    AST_TODO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_byte_stb && shift_run && !req_wr) |=> ($past(todo_bytes) - todo_bytes == CNT_W'(1))); // R3
    AST_REQ_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        req_wr |=> (todo_bytes == $past(req_bytes))); // R7
    AST_STB_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_byte_stb && !shift_run && !req_wr) |=> $stable(todo_bytes)); // R9
    AST_VB_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> (fifo_vbytes == 3'd0)); // R5
    AST_VB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_empty |-> (fifo_vbytes != 3'd0 && fifo_vbytes <= 3'd4)); // R5
endmodule

bind rx_req_packer rx_req_packer_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_bytes(req_bytes),
    .rx_byte_stb(rx_byte_stb), .shift_run(shift_run), .todo_bytes(todo_bytes),
    .fifo_vbytes(fifo_vbytes), .fifo_level(fifo_level), .fifo_empty(fifo_empty)
);

// File: tb/rx_req_packer_bench.sv
// Scoreboard bench: driver tasks model packing and queue expected words; a monitor pops and compares.
module rx_req_packer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;
    localparam int CNT_W = 16;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_wr = 1'b0;
    logic [CNT_W-1:0] req_bytes = '0;
    logic             rx_byte_stb = 1'b0;
    logic [7:0]       rx_byte = 8'h0;
    logic             shift_run;
    logic [CNT_W-1:0] todo_bytes;
    logic             fifo_rd = 1'b0;
    logic [31:0]      fifo_word;
    logic [2:0]       fifo_vbytes;
    logic [LVL_W-1:0] fifo_level;
    logic             fifo_empty;
    logic [5:0]       depth_cap;

    int n_checks = 0;
    int n_fail = 0;
    bit mon_en = 1'b0;
    bit finished = 1'b0;

    logic [34:0] exp_q[$];
    logic [31:0] m_acc = '0;
    int          m_cnt = 0;
    int          m_todo = 0;
    logic [7:0]  next_val = 8'h01;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_req_packer #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx_req_packer (
        .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_bytes(req_bytes),
        .rx_byte_stb(rx_byte_stb), .rx_byte(rx_byte), .shift_run(shift_run),
        .todo_bytes(todo_bytes), .fifo_rd(fifo_rd), .fifo_word(fifo_word),
        .fifo_vbytes(fifo_vbytes), .fifo_level(fifo_level), .fifo_empty(fifo_empty),
        .depth_cap(depth_cap)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Push a held partial or full word into the expected queue.
    task automatic model_push();
        exp_q.push_back({m_acc, 3'(m_cnt)});
        m_acc = '0;
        m_cnt = 0;
    endtask

    task automatic issue_req(input int n);
        @(negedge clk);
        req_wr = 1'b1;
        req_bytes = CNT_W'(n);
        @(negedge clk);
        req_wr = 1'b0;
        m_todo = n;
        if (n == 0 && m_cnt != 0) model_push();
    endtask

    // Drive k bytes, one per cycle whenever the design runs the clock.
    task automatic feed(input int k);
        int got = 0;
        int waited = 0;
        while (got < k) begin
            @(negedge clk);
            if (shift_run) begin
                rx_byte_stb = 1'b1;
                rx_byte = next_val;
                m_acc = (m_acc << 8) | {24'h0, next_val};
                m_cnt++;
                m_todo--;
                next_val = next_val + 8'h01;
                got++;
                if (m_cnt == 4 || m_todo == 0) model_push();
            end else begin
                rx_byte_stb = 1'b0;
                waited++;
                if (waited > 1000) begin
                    check("R6 feed stalled", 64'(got), 64'(k));
                    got = k;
                end
            end
        end
        @(negedge clk);
        rx_byte_stb = 1'b0;
    endtask

    // Monitor: pop the head whenever it is valid and compare with the scoreboard.
    always @(negedge clk) begin
        fifo_rd = 1'b0;
        if (mon_en && !fifo_empty) begin
            if (exp_q.size() == 0) begin
                check("R4 R5 unexpected word", {29'h0, fifo_word, fifo_vbytes}, 64'h0);
            end else begin
                logic [34:0] e;
                e = exp_q.pop_front();
                check("R4 R5 word", {29'h0, fifo_word, fifo_vbytes}, {29'h0, e});
            end
            fifo_rd = 1'b1;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 todo", 64'(todo_bytes), 64'h0);
        check("R1 run", 64'(shift_run), 64'h0);
        check("R1 empty", 64'(fifo_empty), 64'h1);
        check("R1 vbytes", 64'(fifo_vbytes), 64'h0);
        // R8 depth field
        check("R8 depth", 64'(depth_cap), 64'(DEPTH));

        // R9 strobe while idle is ignored
        @(negedge clk);
        rx_byte_stb = 1'b1;
        rx_byte = 8'hEE;
        @(negedge clk);
        rx_byte_stb = 1'b0;
        check("R9 todo idle", 64'(todo_bytes), 64'h0);
        check("R9 level idle", 64'(fifo_level), 64'h0);

        mon_en = 1'b1;
        // R2 request load and run
        issue_req(8);
        check("R2 todo load", 64'(todo_bytes), 64'd8);
        check("R2 run high", 64'(shift_run), 64'h1);
        feed(5);
        check("R3 todo after 5", 64'(todo_bytes), 64'd3);
        feed(3);
        check("R3 run low at zero", 64'(shift_run), 64'h0);
        check("R3 todo zero", 64'(todo_bytes), 64'h0);

        // R5 partial words of 3 and 1 bytes
        issue_req(3);
        feed(3);
        issue_req(1);
        feed(1);

        // R7 replacement mid-word
        issue_req(10);
        feed(3);
        issue_req(5);
        check("R7 replaced todo", 64'(todo_bytes), 64'd5);
        feed(5);

        // R10 zero request flushes held bytes
        issue_req(6);
        feed(2);
        issue_req(0);
        check("R10 todo zero", 64'(todo_bytes), 64'h0);
        repeat (4) @(negedge clk);

        // R6 full FIFO pauses the clock
        mon_en = 1'b0;
        issue_req(4 * DEPTH + 2);
        feed(4 * DEPTH);
        check("R6 run paused", 64'(shift_run), 64'h0);
        check("R6 level full", 64'(fifo_level), 64'(DEPTH));
        check("R6 todo left", 64'(todo_bytes), 64'd2);
        rx_byte_stb = 1'b1;
        rx_byte = 8'hAA;
        @(negedge clk);
        rx_byte_stb = 1'b0;
        check("R9 todo while paused", 64'(todo_bytes), 64'd2);
        check("R9 level while paused", 64'(fifo_level), 64'(DEPTH));
        mon_en = 1'b1;
        feed(2);

        repeat (40) @(negedge clk);
        check("R5 scoreboard drained", 64'(exp_q.size()), 64'h0);
        check("R5 fifo empty at end", 64'(fifo_empty), 64'h1);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule